// File: doc/BRIEF.md
# I2C Bus Ownership Arbiter

This block decides who may drive a shared I2C engine at any moment: a software requester working through control bits, or an internal hardware requester that runs its own transfers. It keeps a three-valued ownership status (idle, software, hardware) that software can read back. Two grant outputs enable the engine for the winning side. Software starts with a GO pulse and hands the bus back with a done pulse. Hardware holds a request level and signals the end of its transfer with a done pulse. During a transfer it also pulses a byte-boundary strobe.

A priority level decides how a software GO meets a busy hardware owner. At normal priority the GO is parked in a one-entry pending slot and runs as soon as hardware lets go. A control bit can forbid this parking, in which case the GO is dropped and a sticky flag records the refusal. At high priority the GO pre-empts hardware at its next byte boundary. Software may ask for a soft reset of the engine, but the request only goes through while software owns the bus. A status-reset pulse clears the sticky flags.

States: `ST_IDLE`, `ST_SW` (software owns), `ST_HW` (hardware owns), `ST_HW_YIELD` (hardware still owns, a high-priority software GO waits for the byte boundary). Transitions:
- IDLE→HW: hardware request wins.
- IDLE→SW: a software GO wins.
- SW→IDLE: done pulse.
- HW→IDLE: hardware done with nothing pending.
- HW→SW: hardware done with a GO pending.
- HW→HW_YIELD: high-priority GO.
- HW_YIELD→SW: byte boundary or hardware done.

Top module: `i2c_bus_arbiter`

## Requirements
- R1: After reset, `own_status` is 0, both grants are low, `go_pending` is 0, `flags` is 0 and `soft_reset_out` is 0.
- R2: `own_status` is 0 for idle, 1 when software owns and 2 when hardware owns. `sw_grant` is high exactly when the status is 1 and `hw_grant` exactly when it is 2. The two grants are never high together.
- R3: From idle, a lone `sw_go` makes software the owner on the next clock edge. A lone `hw_req` makes hardware the owner on the next clock edge.
- R4: When `hw_req` and `sw_go` arrive together in idle, hardware wins if `sw_prio_high` is 0 (the GO is then treated as arriving under hardware ownership), and software wins if `sw_prio_high` is 1.
- R5: A `sw_done` pulse while software owns returns the status to idle on the next edge.
- R6: A grant holds until its owner releases it. Software ownership ignores `hw_req` and further `sw_go` pulses. Hardware ownership ends only on `hw_done`, or by pre-emption as in R7.
- R7: With `sw_prio_high`=1, a `sw_go` during hardware ownership leaves `hw_grant` high until `hw_byte_end` (or `hw_done`). Software owns from the following edge. A pre-emption at a byte boundary, without `hw_done`, sets `flags[1]`.
- R8: With `sw_prio_high`=0 and `no_queue_go`=0, a `sw_go` during hardware ownership sets `go_pending`. On `hw_done`, software owns the bus from the next edge and `go_pending` clears.
- R9: With `sw_prio_high`=0 and `no_queue_go`=1, a `sw_go` during hardware ownership is dropped and sets `flags[0]`. A later `hw_done` returns the bus to idle.
- R10: `soft_reset_out` pulses one cycle after `soft_reset_req` only if the status was 1 at that edge. Otherwise the request has no effect.
- R11: `status_reset` clears `flags` on the next edge and takes precedence over any flag being set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_go | input | 1 | Software GO pulse |
| sw_done | input | 1 | Software done-using pulse |
| sw_prio_high | input | 1 | Software priority: 0 normal, 1 high |
| no_queue_go | input | 1 | 1 forbids parking a software GO under hardware ownership |
| hw_req | input | 1 | Hardware request level |
| hw_byte_end | input | 1 | Hardware byte-boundary strobe |
| hw_done | input | 1 | Hardware transfer-finished pulse |
| soft_reset_req | input | 1 | Software soft-reset request pulse |
| status_reset | input | 1 | Clears the sticky flags |
| sw_grant | output | 1 | Engine granted to software |
| hw_grant | output | 1 | Engine granted to hardware |
| own_status | output | 2 | Ownership status readback |
| go_pending | output | 1 | A parked software GO is waiting |
| flags | output | 2 | bit0 GO refused, bit1 hardware pre-empted |
| soft_reset_out | output | 1 | Gated soft reset pulse to the engine |

## Verification
The bench stresses the simultaneous idle request under both priority levels. A design with the tie-break reversed would hand the bus to the wrong side. It pre-empts hardware at high priority and confirms the grant waits for the byte boundary. A design that switched at once would tear a byte in half. It parks a GO and refuses a GO, then checks that the parked one runs on `hw_done` and that the refused one leaves the bus idle. Soft reset is requested under software, hardware and idle ownership. A status reset is also applied in the same cycle as a refusal, where a design with the wrong precedence would leave the flag set.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int STATUS_W = 2;
    localparam int FLAG_W   = 2;
    localparam int FLAG_REFUSED   = 0;
    localparam int FLAG_PREEMPTED = 1;

    localparam logic [STATUS_W-1:0] STAT_IDLE = 2'd0;
    localparam logic [STATUS_W-1:0] STAT_SW   = 2'd1;
    localparam logic [STATUS_W-1:0] STAT_HW   = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SW       = 2'd1,
        ST_HW       = 2'd2,
        ST_HW_YIELD = 2'd3
    } own_state_e;
endpackage

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_go,
    input  logic       sw_done,
    input  logic       prio_high,
    input  logic       hw_req,
    input  logic       hw_byte_end,
    input  logic       hw_done,
    input  logic       queued,
    output own_state_e state,
    output logic       queue_evt,
    output logic       enter_sw,
    output logic       yield_evt
);
    own_state_e state_q, state_d;
    logic       sw_want;

    assign sw_want = sw_go | queued;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        queue_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hw_req && sw_want) begin
                    if (prio_high) begin
                        state_d = ST_SW;
                    end else begin
                        state_d   = ST_HW;
                        queue_evt = sw_go;
                    end
                end else if (hw_req) begin
                    state_d = ST_HW;
                end else if (sw_want) begin
                    state_d = ST_SW;
                end
            end
            ST_SW: begin
                if (sw_done) state_d = ST_IDLE;
            end
            ST_HW: begin
                if (hw_done)                    state_d = sw_want ? ST_SW : ST_IDLE;
                else if (sw_want && prio_high)  state_d = ST_HW_YIELD;
                else                            queue_evt = sw_go;
            end
            ST_HW_YIELD: begin
                if (hw_byte_end || hw_done) state_d = ST_SW;
            end
        endcase
    end

    assign state     = state_q;
    assign enter_sw  = (state_d == ST_SW) && (state_q != ST_SW);
    assign yield_evt = (state_q == ST_HW_YIELD) && hw_byte_end && !hw_done;
endmodule

// File: rtl/arb_go_queue.sv
module arb_go_queue (
    input  logic clk,
    input  logic rst_n,
    input  logic queue_evt,
    input  logic no_queue,
    input  logic enter_sw,
    output logic queued,
    output logic refuse_evt
);
    logic queued_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      queued_q <= 1'b0;
        else if (enter_sw)               queued_q <= 1'b0;
        else if (queue_evt && !no_queue) queued_q <= 1'b1;
    end

    assign queued     = queued_q;
    assign refuse_evt = queue_evt & no_queue;
endmodule

// File: rtl/arb_flag_gate.sv
module arb_flag_gate
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refuse_evt,
    input  logic              yield_evt,
    input  logic              status_reset,
    input  logic              soft_reset_req,
    input  logic              sw_owned,
    output logic [FLAG_W-1:0] flags,
    output logic              soft_reset_out
);
    logic [FLAG_W-1:0] flags_q, set_vec;
    logic              srst_q;

    always_comb begin
        set_vec                 = '0;
        set_vec[FLAG_REFUSED]   = refuse_evt;
        set_vec[FLAG_PREEMPTED] = yield_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            srst_q  <= 1'b0;
        end else begin
            flags_q <= status_reset ? '0 : (flags_q | set_vec);
            srst_q  <= soft_reset_req & sw_owned;
        end
    end

    assign flags          = flags_q;
    assign soft_reset_out = srst_q;
endmodule

// File: rtl/i2c_bus_arbiter.sv
module i2c_bus_arbiter
    import arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_go,
    input  logic                sw_done,
    input  logic                sw_prio_high,
    input  logic                no_queue_go,
    input  logic                hw_req,
    input  logic                hw_byte_end,
    input  logic                hw_done,
    input  logic                soft_reset_req,
    input  logic                status_reset,
    output logic                sw_grant,
    output logic                hw_grant,
    output logic [STATUS_W-1:0] own_status,
    output logic                go_pending,
    output logic [FLAG_W-1:0]   flags,
    output logic                soft_reset_out
);
    own_state_e state;
    logic       queue_evt, enter_sw, yield_evt, refuse_evt, queued;

    arb_owner_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sw_go(sw_go), .sw_done(sw_done),
        .prio_high(sw_prio_high), .hw_req(hw_req), .hw_byte_end(hw_byte_end),
        .hw_done(hw_done), .queued(queued), .state(state),
        .queue_evt(queue_evt), .enter_sw(enter_sw), .yield_evt(yield_evt)
    );

    arb_go_queue u_queue (
        .clk(clk), .rst_n(rst_n), .queue_evt(queue_evt), .no_queue(no_queue_go),
        .enter_sw(enter_sw), .queued(queued), .refuse_evt(refuse_evt)
    );

    arb_flag_gate u_flags (
        .clk(clk), .rst_n(rst_n), .refuse_evt(refuse_evt), .yield_evt(yield_evt),
        .status_reset(status_reset), .soft_reset_req(soft_reset_req),
        .sw_owned(state == ST_SW), .flags(flags), .soft_reset_out(soft_reset_out)
    );

    always_comb begin
        sw_grant   = 1'b0;
        hw_grant   = 1'b0;
        own_status = STAT_IDLE;
        unique case (state)
            ST_IDLE: ;
            ST_SW: begin
                sw_grant   = 1'b1;
                own_status = STAT_SW;
            end
            ST_HW, ST_HW_YIELD: begin
                hw_grant   = 1'b1;
                own_status = STAT_HW;
            end
        endcase
    end

    assign go_pending = queued;
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_go,
    input logic       sw_done,
    input logic       sw_prio_high,
    input logic       no_queue_go,
    input logic       hw_req,
    input logic       hw_byte_end,
    input logic       hw_done,
    input logic       soft_reset_req,
    input logic       status_reset,
    input logic       sw_grant,
    input logic       hw_grant,
    input logic [1:0] own_status,
    input logic [1:0] flags,
    input logic       soft_reset_out
);
    assert_grant_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_grant && hw_grant));
    assert_sw_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_grant |-> own_status == 2'd1);
    assert_tie_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_status == 2'd0 && hw_req && sw_go && !sw_prio_high) |=> hw_grant);
    assert_tie_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_status == 2'd0 && hw_req && sw_go && sw_prio_high) |=> sw_grant);
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_status == 2'd1 && sw_done) |=> own_status == 2'd0);
    assert_hw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_grant && !hw_done && !hw_byte_end) |=> hw_grant);
    assert_yield_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (own_status == 2'd2 && sw_go && sw_prio_high && !hw_done) |=> hw_grant);
    assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (own_status == 2'd2 && sw_go && !sw_prio_high && no_queue_go && !hw_done
         && !status_reset) |=> flags[0]);
    assert_srst_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_reset_req && own_status != 2'd1) |=> !soft_reset_out);
    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status_reset |=> flags == 2'b00);
endmodule

bind i2c_bus_arbiter arb_checker u_arb_checker (
    .clk(clk), .rst_n(rst_n), .sw_go(sw_go), .sw_done(sw_done),
    .sw_prio_high(sw_prio_high), .no_queue_go(no_queue_go), .hw_req(hw_req),
    .hw_byte_end(hw_byte_end), .hw_done(hw_done), .soft_reset_req(soft_reset_req),
    .status_reset(status_reset), .sw_grant(sw_grant), .hw_grant(hw_grant),
    .own_status(own_status), .flags(flags), .soft_reset_out(soft_reset_out)
);

// File: tb/test_i2c_bus_arbiter.sv
module test_i2c_bus_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_go = 0, sw_done = 0, sw_prio_high = 0, no_queue_go = 0;
    logic hw_req = 0, hw_byte_end = 0, hw_done = 0;
    logic soft_reset_req = 0, status_reset = 0;
    logic sw_grant, hw_grant, go_pending, soft_reset_out;
    logic [1:0] own_status, flags;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2c_bus_arbiter i_i2c_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .sw_go(sw_go), .sw_done(sw_done),
        .sw_prio_high(sw_prio_high), .no_queue_go(no_queue_go), .hw_req(hw_req),
        .hw_byte_end(hw_byte_end), .hw_done(hw_done), .soft_reset_req(soft_reset_req),
        .status_reset(status_reset), .sw_grant(sw_grant), .hw_grant(hw_grant),
        .own_status(own_status), .go_pending(go_pending), .flags(flags),
        .soft_reset_out(soft_reset_out)
    );

    // Behavioural reference: owner 0 idle, 1 software, 2 hardware, 3 hardware yielding
    int m_own = 0;
    int m_pend = 0;
    int m_refused = 0;
    int m_preempt = 0;
    int m_srst = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_own = 0; m_pend = 0; m_refused = 0; m_preempt = 0; m_srst = 0;
        end else begin
            int nxt;
            int want;
            int park;
            int yielded;
            nxt = m_own; park = 0; yielded = 0;
            want = (sw_go || m_pend != 0) ? 1 : 0;
            if (m_own == 0) begin
                if (hw_req && want != 0) begin
                    if (sw_prio_high) nxt = 1;
                    else begin nxt = 2; park = sw_go; end
                end else if (hw_req) nxt = 2;
                else if (want != 0) nxt = 1;
            end else if (m_own == 1) begin
                if (sw_done) nxt = 0;
            end else if (m_own == 2) begin
                if (hw_done) nxt = (want != 0) ? 1 : 0;
                else if (want != 0 && sw_prio_high) nxt = 3;
                else park = sw_go;
            end else begin
                if (hw_byte_end || hw_done) begin
                    nxt = 1;
                    yielded = (hw_byte_end && !hw_done) ? 1 : 0;
                end
            end
            m_srst = (soft_reset_req && m_own == 1) ? 1 : 0;
            if (status_reset) begin
                m_refused = 0; m_preempt = 0;
            end else begin
                if (park != 0 && no_queue_go) m_refused = 1;
                if (yielded != 0) m_preempt = 1;
            end
            if (nxt == 1 && m_own != 1) m_pend = 0;
            else if (park != 0 && !no_queue_go) m_pend = 1;
            m_own = nxt;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 status", own_status, (m_own == 3) ? 2 : m_own);
            chk("R2 sw_grant", sw_grant, (m_own == 1) ? 1 : 0);
            chk("R2 hw_grant", hw_grant, (m_own >= 2) ? 1 : 0);
            chk("R8 go_pending", go_pending, m_pend);
            chk("R11 flags", flags, m_preempt * 2 + m_refused);
            chk("R10 soft_reset_out", soft_reset_out, m_srst);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R1 status", own_status, 0);
        chk("R1 grants", {sw_grant, hw_grant}, 0);
        chk("R1 flags", flags, 0);
        chk("R1 pending", go_pending, 0);
        chk("R1 srst", soft_reset_out, 0);
        rst_n = 1;
        tick();

        // software alone, then hold against hardware
        sw_go = 1; tick(); sw_go = 0;
        chk("R3 sw owns", own_status, 1);
        hw_req = 1; sw_go = 1; tick(); sw_go = 0; tick(); tick();
        chk("R6 sw holds", own_status, 1);
        soft_reset_req = 1; tick(); soft_reset_req = 0;
        chk("R10 srst under sw", soft_reset_out, 1);
        sw_done = 1; tick(); sw_done = 0;
        chk("R5 released", own_status, 0);
        tick();
        chk("R3 hw owns", own_status, 2);

        // hardware owns: soft reset blocked, GO parked
        soft_reset_req = 1; tick(); soft_reset_req = 0;
        chk("R10 srst blocked", soft_reset_out, 0);
        sw_go = 1; tick(); sw_go = 0; tick();
        chk("R8 parked", go_pending, 1);
        chk("R6 hw holds", own_status, 2);
        hw_done = 1; tick(); hw_done = 0;
        chk("R8 sw after hw", own_status, 1);
        chk("R8 pending cleared", go_pending, 0);
        sw_done = 1; tick(); sw_done = 0; tick();
        chk("R3 hw again", own_status, 2);

        // refused GO, status reset
        no_queue_go = 1;
        sw_go = 1; tick(); sw_go = 0;
        chk("R9 refused flag", flags, 1);
        chk("R9 not parked", go_pending, 0);
        hw_req = 0; hw_done = 1; tick(); hw_done = 0;
        chk("R9 idle after hw", own_status, 0);
        soft_reset_req = 1; tick(); soft_reset_req = 0;
        chk("R10 srst idle", soft_reset_out, 0);
        status_reset = 1; tick(); status_reset = 0;
        chk("R11 cleared", flags, 0);
        no_queue_go = 0;

        // simultaneous requests from idle
        hw_req = 1; sw_go = 1; tick(); sw_go = 0;
        chk("R4 normal tie hw", own_status, 2);
        chk("R4 loser parked", go_pending, 1);
        hw_done = 1; tick(); hw_done = 0;
        chk("R8 parked runs", own_status, 1);
        hw_req = 0; sw_done = 1; tick(); sw_done = 0; tick();
        sw_prio_high = 1; hw_req = 1; sw_go = 1; tick(); sw_go = 0;
        chk("R4 high tie sw", own_status, 1);
        sw_done = 1; tick(); sw_done = 0;
        chk("R5 idle", own_status, 0);
        tick();
        chk("R3 hw takes", own_status, 2);

        // high-priority pre-emption
        sw_go = 1; tick(); sw_go = 0;
        chk("R7 waits", hw_grant, 1);
        tick();
        chk("R7 still waits", own_status, 2);
        hw_byte_end = 1; tick(); hw_byte_end = 0;
        chk("R7 sw after byte", own_status, 1);
        chk("R7 preempt flag", flags, 2);
        status_reset = 1; tick(); status_reset = 0;
        chk("R11 cleared again", flags, 0);

        // status reset wins over a refusal in the same cycle
        sw_prio_high = 0; no_queue_go = 1;
        sw_done = 1; tick(); sw_done = 0; tick();
        chk("R3 hw back", own_status, 2);
        sw_go = 1; status_reset = 1; tick(); sw_go = 0; status_reset = 0;
        chk("R11 precedence", flags, 0);
        hw_req = 0; hw_done = 1; tick(); hw_done = 0;
        chk("R9 idle", own_status, 0);
        no_queue_go = 0;
        repeat (3) tick();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule